// File: doc/BRIEF.md
# Serial ADC frame reader

This block is the host side of a link to a 12-bit serial analog-to-digital converter. A one-cycle start request begins a read. The block then generates a serial clock that idles low, drives either a chip-select or a frame-sync strobe, and shifts in a 16-position word. The data line carries the MSB first. The converter changes the line on rising serial-clock edges, so the reader samples on falling edges. The upper twelve positions of the word form an unsigned straight-binary result: 000h is zero scale and FFFh is full scale less one LSB. The lower four positions carry no meaning and are dropped. The result appears at a parallel output, qualified by a one-cycle valid pulse.

The framing scheme is chosen per read by `fs_mode`, and the half period of the serial clock by `half_div`. Both are latched when a read is accepted. Each read begins with a lead phase, in which one full serial-clock pulse is sent while the strobe is still in its pre-frame level. This guarantees the converter sees a falling clock edge while the select is high, or while frame sync is high. The returning data line passes through a two-stage synchronizer, and the sampling point is delayed by the same amount.

The controller has four states. ST_IDLE goes to ST_LEAD when start is asserted. ST_LEAD sends the lead pulse and goes to ST_SHIFT on its third half-period boundary, when the strobe enters its frame level. ST_SHIFT generates sixteen clock pulses and goes to ST_TAIL on the sixteenth falling edge. ST_TAIL returns to ST_IDLE on the first half-period boundary at which all sixteen samples have been captured. That return raises the valid pulse and, in chip-select mode, deasserts the select.

Top module: `adc_frame_rd`

## Requirements
- R1: After reset, sclk is 0, cs_n is 1, fs is 1, busy is 0, res_valid is 0 and result is 0.
- R2: start is accepted only while busy is 0. From the clock edge that accepts it, busy is 1 until the edge that raises res_valid, where it falls. A start while busy is 1 has no effect on any output.
- R3: sclk idles low. While busy, every level of sclk lasts exactly H system clocks, where H is half_div latched at acceptance (mode and half_div changes during a read have no effect). The first rising edge comes H clocks after acceptance.
- R4: With fs_mode=0 (chip-select), fs stays 1. cs_n is 1 during the lead pulse (sclk high for clocks H..2H-1 after acceptance). cs_n goes low 3H clocks after acceptance and rises with res_valid, so at least one falling sclk edge occurs while cs_n is high before each falling cs_n.
- R5: With fs_mode=1 (frame-sync), fs is 1 from acceptance until 3H clocks later and then 0. cs_n keeps its previous idle level through the lead pulse (1 after a chip-select read or reset, otherwise 0). cs_n is then 0, and stays 0 after the read.
- R6: sdo is sampled at each of the sixteen falling sclk edges following the strobe change, MSB first. result equals bits 15..4 of the word, and bits 3..0 have no effect.
- R7: res_valid is high for exactly one cycle. It rises D clocks after the sixteenth falling edge, where D is the smallest multiple of H that is at least 4. result holds its value until the next pulse.
- R8: When idle after a read, cs_n=1 and fs=1 if that read was chip-select mode, and cs_n=0 and fs=0 if it was frame-sync mode.
- R9: half_div=0 is treated as H=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Read request, accepted while idle |
| fs_mode | input | 1 | 0 = chip-select framing, 1 = frame-sync framing |
| half_div | input | DIV_W | Serial clock half period in system clocks |
| sdo | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low select |
| fs | output | 1 | Frame-sync strobe |
| busy | output | 1 | Read in progress |
| res_valid | output | 1 | One-cycle result qualifier |
| result | output | RES_W | 12-bit unsigned conversion result |

## Verification
The bench builds the block with DIV_W=4 and the default sixteen-position frame and two synchronizer stages. It drives half-period values 0, 1, 2, 3, 4 and 5. These cover the clamp of zero, a divider so short that the synchronizer delay spans several serial-clock levels, and the cases where the tail padding is exactly 4 clocks, 5 clocks or a rounded-up 6 clocks. Mode switches in both directions bring the lead-phase select levels within reach. A held start request exercises back-to-back reads, and changes made during a read exercise the latching of the configuration.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } rd_state_t;

    // half-period boundaries spent in the lead phase: rise, fall, strobe change
    localparam int unsigned LEAD_TICKS = 3;

endpackage

// File: rtl/adcrd_tick.sv
module adcrd_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_q,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the half-period counter never runs past its boundary
    assert_tick_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half_q));

endmodule

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] ff_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff_q[0] <= 1'b0;
                    else        ff_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff_q[i] <= 1'b0;
                    else        ff_q[i] <= ff_q[i-1];
                end
            end
        end
    endgenerate

    assign q = ff_q[STAGES-1];

endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift #(
    parameter int FRAME_BITS = 16,
    parameter int RES_W      = 12,
    parameter int STAGES     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fall,
    input  logic             sdo_s,
    output logic             cap_done,
    output logic [RES_W-1:0] word
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic [STAGES-1:0]     dly_q;
    logic                  cap;
    logic [FRAME_BITS-1:0] sreg_q;
    logic [CNT_W-1:0]      n_q;

    // delay the falling-edge marker by the synchronizer depth
    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_dly
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) dly_q[0] <= 1'b0;
                    else        dly_q[0] <= fall;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) dly_q[i] <= 1'b0;
                    else        dly_q[i] <= dly_q[i-1];
                end
            end
        end
    endgenerate

    assign cap = dly_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            n_q    <= '0;
        end else if (clear) begin
            n_q    <= '0;
        end else if (cap) begin
            sreg_q <= {sreg_q[FRAME_BITS-2:0], sdo_s};
            n_q    <= n_q + 1'b1;
        end
    end

    assign cap_done = (n_q == CNT_W'(FRAME_BITS));
    assign word     = sreg_q[FRAME_BITS-1 -: RES_W];

    // R6: no more than one frame's worth of samples per read
    assert_no_overcapture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (n_q < CNT_W'(FRAME_BITS)));

endmodule

// File: rtl/adc_frame_rd.sv
module adc_frame_rd
    import adcrd_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int RES_W       = 12,
    parameter int FRAME_BITS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fs_mode,
    input  logic [DIV_W-1:0] half_div,
    input  logic             sdo,
    output logic             sclk,
    output logic             cs_n,
    output logic             fs,
    output logic             busy,
    output logic             res_valid,
    output logic [RES_W-1:0] result
);

    localparam int FALL_W = $clog2(FRAME_BITS + 1);
    localparam logic [FALL_W-1:0] LAST_FALL = FALL_W'(FRAME_BITS - 1);
    localparam logic [1:0] LEAD_LAST = 2'(LEAD_TICKS - 1);

    rd_state_t         state_q, state_d;
    logic              mode_q, mode_n;
    logic [DIV_W-1:0]  hd_q;
    logic [1:0]        lead_q;
    logic [FALL_W-1:0] nfall_q;
    logic              accept, tick, toggle, finish;
    logic              sdo_s, cap_done;
    logic [RES_W-1:0]  word;

    logic              sclk_q, fall_q, cs_n_q, fs_q, busy_q, valid_q;
    logic [RES_W-1:0]  result_q;

    adcrd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q != ST_IDLE),
        .half_q (hd_q),
        .tick   (tick)
    );

    adcrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sdo),
        .q     (sdo_s)
    );

    adcrd_shift #(
        .FRAME_BITS (FRAME_BITS),
        .RES_W      (RES_W),
        .STAGES     (SYNC_STAGES)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .fall     (fall_q),
        .sdo_s    (sdo_s),
        .cap_done (cap_done),
        .word     (word)
    );

    assign accept = (state_q == ST_IDLE) && start;
    assign mode_n = accept ? fs_mode : mode_q;
    assign toggle = tick && ((state_q == ST_SHIFT) ||
                             ((state_q == ST_LEAD) && (lead_q != LEAD_LAST)));
    assign finish = (state_q == ST_TAIL) && (state_d == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                                       state_d = ST_LEAD;
            ST_LEAD:  if (tick && lead_q == LEAD_LAST)                 state_d = ST_SHIFT;
            ST_SHIFT: if (tick && sclk_q && nfall_q == LAST_FALL)      state_d = ST_TAIL;
            ST_TAIL:  if (tick && cap_done)                            state_d = ST_IDLE;
            default:                                                   state_d = ST_IDLE;
        endcase
    end

    // state register and per-read configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            hd_q    <= DIV_W'(1);
            lead_q  <= '0;
            nfall_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q  <= fs_mode;
                hd_q    <= (half_div == '0) ? DIV_W'(1) : half_div;
                nfall_q <= '0;
            end else if (state_q == ST_SHIFT && tick && sclk_q) begin
                nfall_q <= nfall_q + 1'b1;
            end
            if (state_q != ST_LEAD) lead_q <= '0;
            else if (tick)          lead_q <= lead_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            fall_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            fs_q     <= 1'b1;
            busy_q   <= 1'b0;
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            sclk_q  <= toggle ? ~sclk_q : sclk_q;
            fall_q  <= (state_q == ST_SHIFT) && tick && sclk_q;
            busy_q  <= (state_d != ST_IDLE);
            valid_q <= finish;
            if (finish) result_q <= word;
            unique case (state_d)
                ST_IDLE: begin
                    cs_n_q <= ~mode_n;
                    fs_q   <= ~mode_n;
                end
                ST_LEAD: begin
                    cs_n_q <= mode_n ? cs_n_q : 1'b1;
                    fs_q   <= 1'b1;
                end
                ST_SHIFT, ST_TAIL: begin
                    cs_n_q <= 1'b0;
                    fs_q   <= ~mode_n;
                end
                default: begin
                    cs_n_q <= 1'b1;
                    fs_q   <= 1'b1;
                end
            endcase
        end
    end

    assign sclk      = sclk_q;
    assign cs_n      = cs_n_q;
    assign fs        = fs_q;
    assign busy      = busy_q;
    assign res_valid = valid_q;
    assign result    = result_q;

    // R3: serial clock rests low whenever no read is running
    assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);

    // R3: configuration is frozen for the length of a read
    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(hd_q) && $stable(mode_q)));

    // R4: frame sync stays high throughout a chip-select read
    assert_fs_high_cs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && busy_q) |-> fs_q);

    // R4 / R5: select is active while bits are being shifted
    assert_select_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT || state_q == ST_TAIL) |-> !cs_n_q);

    // R7: the valid qualifier lasts a single cycle
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R2: a valid pulse coincides with the end of busy
    assert_valid_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (!busy_q && $past(busy_q)));

endmodule

// File: tb/sim_adc_frame_rd.sv
`timescale 1ns/1ps
module sim_adc_frame_rd;

    localparam int DIV_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             fs_mode = 1'b0;
    logic [DIV_W-1:0] half_div = '0;
    logic             sdo = 1'b0;
    logic             sclk, cs_n, fs, busy, res_valid;
    logic [11:0]      result;

    logic [15:0]      word = 16'h0000;
    string            cur_tag = "R6";

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int valid_cnt = 0;

    always #2.5 clk = ~clk;

    adc_frame_rd #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fs_mode(fs_mode),
        .half_div(half_div), .sdo(sdo), .sclk(sclk), .cs_n(cs_n), .fs(fs),
        .busy(busy), .res_valid(res_valid), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     tag, what, act, exp, cyc);
        end
    endtask

    // converter model: shifts out the next bit on every rising sclk edge
    int pidx = -1;
    always @(negedge cs_n or negedge fs) pidx = 15;
    always @(posedge sclk) begin
        if (pidx >= 0) begin
            sdo <= word[pidx];
            pidx = pidx - 1;
        end
    end

    // control-capture rule: a falling sclk edge while the strobe is high
    int falls_cs_hi = 0;
    int falls_fs_hi = 0;
    always @(negedge sclk) begin
        if (cs_n) falls_cs_hi++;
        if (fs)   falls_fs_hi++;
    end
    always @(posedge cs_n) falls_cs_hi = 0;
    always @(posedge fs)   falls_fs_hi = 0;
    always @(negedge cs_n) if (rst_n)
        chk(falls_cs_hi >= 1, "R4", "falls while cs_n high", falls_cs_hi, 1);
    always @(negedge fs) if (rst_n)
        chk(falls_fs_hi >= 1, "R5", "falls while fs high", falls_fs_hi, 1);

    // cycle-by-cycle reference model
    bit         m_busy = 0, m_mode = 0, m_last_mode = 0, m_lead_cs = 1;
    int         c = 0, m_hd = 1, m_exit = 0;
    logic [11:0] m_exp = '0;
    bit         st_prev = 0, mode_prev = 0;
    int         hd_prev = 0;
    logic [15:0] word_prev = '0;

    always @(negedge clk) begin
        bit e_sclk, e_cs, e_fs, e_busy, e_valid;
        int k;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (!rst_n) begin
            m_busy = 0; m_last_mode = 0; st_prev = 0;
        end else begin
            if (!m_busy && st_prev) begin
                m_busy = 1; c = 0;
                m_hd   = (hd_prev == 0) ? 1 : hd_prev;
                m_mode = mode_prev;
                m_exp  = word_prev[15:4];
                m_lead_cs = m_mode ? !m_last_mode : 1'b1;
                // 3 lead boundaries + 32 shift boundaries, then tail padding
                m_exit = m_hd * (35 + (4 + m_hd - 1) / m_hd);
            end else if (m_busy) begin
                c++;
            end
            e_valid = 0;
            if (m_busy && c == m_exit) begin
                e_valid = 1; e_busy = 0; e_sclk = 0;
                m_busy = 0; m_last_mode = m_mode;
                e_cs = !m_mode; e_fs = !m_mode;
                chk(result == m_exp, cur_tag, "result", result, m_exp);
            end else if (m_busy) begin
                k = c / m_hd;
                e_busy = 1;
                e_sclk = (k == 1) || (k >= 4 && k <= 34 && (k % 2) == 0);
                if (c < 3 * m_hd) begin
                    e_cs = m_lead_cs; e_fs = 1'b1;
                end else begin
                    e_cs = 1'b0; e_fs = !m_mode;
                end
            end else begin
                e_busy = 0; e_sclk = 0;
                e_cs = !m_last_mode; e_fs = !m_last_mode;
            end
            if (res_valid) valid_cnt++;
            chk(sclk == e_sclk, "R3", "sclk", sclk, e_sclk);
            chk(cs_n == e_cs, m_mode ? "R5" : "R4", "cs_n", cs_n, e_cs);
            chk(fs == e_fs, e_busy ? (m_mode ? "R5" : "R4") : "R8", "fs", fs, e_fs);
            chk(busy == e_busy, "R2", "busy", busy, e_busy);
            chk(res_valid == e_valid, "R7", "res_valid", res_valid, e_valid);
        end
        st_prev = start; mode_prev = fs_mode; hd_prev = half_div; word_prev = word;
    end

    task automatic wait_idle();
        int n = 0;
        repeat (3) @(negedge clk);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input bit m, input int h, input logic [15:0] w, input string tag);
        @(posedge clk); #1;
        fs_mode = m; half_div = h[DIV_W-1:0]; word = w; cur_tag = tag; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_idle();
    endtask

    initial begin
        int vc;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
        chk(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
        chk(fs == 1'b1, "R1", "reset fs", fs, 1);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(res_valid == 1'b0, "R1", "reset res_valid", res_valid, 0);
        chk(result == 12'h000, "R1", "reset result", result, 0);

        frame(1'b0, 2, 16'hA5C7, "R6");
        frame(1'b0, 1, 16'hFFFF, "R4");
        frame(1'b1, 3, 16'h000F, "R5");

        // disturbances during a read: start, mode and divider are ignored
        vc = valid_cnt;
        @(posedge clk); #1;
        fs_mode = 1'b1; half_div = 4'd5; word = 16'h8009; cur_tag = "R3"; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (40) @(posedge clk);
        #1 fs_mode = 1'b0; half_div = 4'd1; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (60) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait_idle();
        chk(valid_cnt == vc + 1, "R2", "valid pulses for one read", valid_cnt - vc, 1);

        frame(1'b0, 0, 16'h1234, "R9");

        // start held high: back-to-back reads in frame-sync mode
        vc = valid_cnt;
        @(posedge clk); #1;
        fs_mode = 1'b1; half_div = 4'd2; word = 16'h5A3C; cur_tag = "R7"; start = 1'b1;
        repeat (100) @(posedge clk);
        #1 start = 1'b0;
        wait_idle();
        chk(valid_cnt == vc + 2, "R2", "valid pulses for held start", valid_cnt - vc, 2);

        frame(1'b0, 4, 16'h0FF0, "R8");
        frame(1'b1, 1, 16'hC3A5, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule